// File: doc/BRIEF.md
# Two-by-Two Packet Switch with Match Counter

This block moves single-beat packets from two input ports to two output ports. Each input port feeds its own small queue. The packet at the head of a queue is routed by a one-bit destination field: clear means output 0 and set means output 1. It is copied into that output's queue when a slot is free. Every port uses a valid/ready handshake. An input port accepts while its queue has room, and an output port presents the head of its queue.

An output queue takes at most one write per clock. When both input heads want the same output in the same cycle, a round-robin arbiter local to that output picks one of them. The other input keeps its packet and tries again on the next cycle. When the two heads want different outputs, both move in the same cycle.

A 32-bit statistics counter counts forwarded packets whose tag field equals a programmable match value. In one cycle it can rise by 0, 1 or 2, so no event is lost when both inputs forward a matching packet together. The counter wraps on overflow.

Top module: `pkt_switch2x2`

## Requirements
- R1: After a synchronous reset, both input ready outputs are 1, both output valid outputs are 0 and the counter reads 0.
- R2: A packet is 13 bits wide. Bit 12 is the destination, bits 11:8 are the tag and bits 7:0 are the payload. Destination 0 delivers the packet on output 0 and destination 1 delivers it on output 1.
- R3: An empty input queue forwards nothing. A packet stays in its input queue while its output queue is full. An input's ready output is 0 while its queue is full.
- R4: Each output queue receives at most one packet per clock. When both inputs target the same output, exactly one of them is forwarded in that cycle.
- R5: Each output arbiter starts out favouring input 0. After every contested cycle in which it forwards a packet, it switches to favour the other input. The losing packet is forwarded on a later cycle.
- R6: A packet accepted on a clock edge shows on its output after the following edge, provided that output queue has room. Heads that target different outputs, each with room, are both forwarded in the same cycle.
- R7: On each clock, the counter adds the number of packets forwarded in that cycle whose tag equals `match_tag` (0, 1 or 2).
- R8: Each queue holds 4 packets. Packets from one input to one output leave in the order they were accepted.
- R9: A new `match_tag` value applies to every packet forwarded after it changes. A packet whose tag differs from it is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Input 0 offers a packet |
| in0_ready | output | 1 | Input 0 queue has room |
| in0_data | input | 13 | Input 0 packet |
| in1_valid | input | 1 | Input 1 offers a packet |
| in1_ready | output | 1 | Input 1 queue has room |
| in1_data | input | 13 | Input 1 packet |
| out0_valid | output | 1 | Output 0 queue is non-empty |
| out0_ready | input | 1 | Downstream takes output 0 packet |
| out0_data | output | 13 | Output 0 head packet |
| out1_valid | output | 1 | Output 1 queue is non-empty |
| out1_ready | input | 1 | Downstream takes output 1 packet |
| out1_data | output | 13 | Output 1 head packet |
| match_tag | input | 4 | Tag value that counts as a match |
| count_value | output | 32 | Running count of matching forwarded packets |

## Verification
The assertions check, on every cycle, the properties that are local to one clock edge:
- no queue is written while full or read while empty;
- each output arbiter grants at most one requester, and only a requester;
- the arbiter priority turns after every contested transfer;
- heads bound for different outputs both move when there is room;
- the counter never steps by more than two.

Only the bench scenarios can show the properties that span many cycles:
- packet order on each input-to-output path;
- the exact count after a burst;
- the one-edge forwarding latency;
- which input wins on successive contests;
- the effect of changing the match value.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int TAG_W      = 4;
    localparam int PAY_W      = 8;
    localparam int PKT_W      = 1 + TAG_W + PAY_W;
    localparam int CNT_W      = 32;
    localparam int FIFO_DEPTH = 4;
    localparam int N_PORTS    = 2;

    typedef struct packed {
        logic             dst;
        logic [TAG_W-1:0] tag;
        logic [PAY_W-1:0] pay;
    } pkt_t;

    function automatic logic tag_hit(input pkt_t p, input logic [TAG_W-1:0] m);
        return p.tag == m;
    endfunction
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= bump(wp_q);
            if (rd_en) rp_q <= bump(rp_q);
            case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign rd_data = mem[rp_q];

    AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) wr_en |-> !full);  // R3
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R3
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] grant
);
    logic favour1_q;
    logic contest;

    assign contest = &req;

    always_comb begin
        if (!take)        grant = '0;
        else if (contest) grant = favour1_q ? N'(2) : N'(1);
        else              grant = req;
    end

    always_ff @(posedge clk) begin
        if (rst)                  favour1_q <= 1'b0;
        else if (contest && take) favour1_q <= ~favour1_q;
    end

    AST_ONE_GRANT:     assert property (@(posedge clk) disable iff (rst) $onehot0(grant));             // R4
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst) (grant & ~req) == '0);      // R4
    AST_RR_FLIP:       assert property (@(posedge clk) disable iff (rst)
                                        (contest && take) |=> (favour1_q != $past(favour1_q)));      // R5
endmodule

// File: rtl/hit_counter.sv
module hit_counter #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] step;

    always_comb begin
        step = '0;
        for (int k = 0; k < N; k++) step = step + W'(inc[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + step;
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
                                   (cnt_q - $past(cnt_q)) <= W'(N));  // R7
endmodule

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2
    import sw_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in0_valid,
    output logic             in0_ready,
    input  logic [PKT_W-1:0] in0_data,
    input  logic             in1_valid,
    output logic             in1_ready,
    input  logic [PKT_W-1:0] in1_data,
    output logic             out0_valid,
    input  logic             out0_ready,
    output logic [PKT_W-1:0] out0_data,
    output logic             out1_valid,
    input  logic             out1_ready,
    output logic [PKT_W-1:0] out1_data,
    input  logic [TAG_W-1:0] match_tag,
    output logic [CNT_W-1:0] count_value
);
    logic [N_PORTS-1:0] in_v, in_full, in_empty, out_full, out_empty, out_rd, out_rdy, fwd, hit_inc;
    logic [N_PORTS-1:0][N_PORTS-1:0] req, gnt;   // [output][input]
    pkt_t in_wdata  [N_PORTS];
    pkt_t in_head   [N_PORTS];
    pkt_t out_wdata [N_PORTS];
    pkt_t out_head  [N_PORTS];

    assign in_v        = {in1_valid, in0_valid};
    assign out_rdy     = {out1_ready, out0_ready};
    assign in_wdata[0] = pkt_t'(in0_data);
    assign in_wdata[1] = pkt_t'(in1_data);

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        pkt_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (in_v[i] & ~in_full[i]),
            .wr_data(in_wdata[i]),
            .full   (in_full[i]),
            .rd_en  (fwd[i]),
            .rd_data(in_head[i]),
            .empty  (in_empty[i])
        );
        assign fwd[i]     = gnt[0][i] | gnt[1][i];
        assign hit_inc[i] = fwd[i] & tag_hit(in_head[i], match_tag);
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        for (genvar i = 0; i < N_PORTS; i++) begin : g_req
            assign req[o][i] = !in_empty[i] && (in_head[i].dst == 1'(o));
        end

        rr_arbiter #(.N(N_PORTS)) u_arb (
            .clk  (clk),
            .rst  (rst),
            .req  (req[o]),
            .take (!out_full[o]),
            .grant(gnt[o])
        );

        assign out_wdata[o] = gnt[o][1] ? in_head[1] : in_head[0];
        assign out_rd[o]    = out_rdy[o] & ~out_empty[o];

        pkt_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (|gnt[o]),
            .wr_data(out_wdata[o]),
            .full   (out_full[o]),
            .rd_en  (out_rd[o]),
            .rd_data(out_head[o]),
            .empty  (out_empty[o])
        );
    end

    hit_counter #(.W(CNT_W), .N(N_PORTS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (hit_inc),
        .count(count_value)
    );

    assign in0_ready  = ~in_full[0];
    assign in1_ready  = ~in_full[1];
    assign out0_valid = ~out_empty[0];
    assign out1_valid = ~out_empty[1];
    assign out0_data  = out_head[0];
    assign out1_data  = out_head[1];

    AST_SPLIT_BOTH_MOVE: assert property (@(posedge clk) disable iff (rst)
        (req[0][0] && req[1][1] && !out_full[0] && !out_full[1]) |-> (fwd == 2'b11));  // R6
    AST_CROSS_BOTH_MOVE: assert property (@(posedge clk) disable iff (rst)
        (req[1][0] && req[0][1] && !out_full[0] && !out_full[1]) |-> (fwd == 2'b11));  // R6
endmodule

// File: tb/pkt_switch2x2_test.sv
module pkt_switch2x2_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in0_valid = 0, in1_valid = 0, out0_ready = 0, out1_ready = 0;
    logic [12:0] in0_data = '0, in1_data = '0;
    logic        in0_ready, in1_ready, out0_valid, out1_valid;
    logic [12:0] out0_data, out1_data;
    logic [3:0]  match_tag = 4'h5;
    logic [31:0] count_value;

    int checks = 0, fails = 0, cycles = 0;
    logic [31:0] exp_cnt = 0, base;
    logic [6:0]  seq = 0;
    logic [12:0] sbq [4][$];

    pkt_switch2x2 uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench packet: {dst, tag, src, seq[6:0]}
    function automatic logic [12:0] mk(input logic dst, input logic [3:0] tag, input logic src, input logic [6:0] s);
        return {dst, tag, src, s};
    endfunction

    function automatic logic [12:0] nxt(input logic dst, input logic [3:0] tag, input logic src);
        seq = seq + 7'd1;
        return mk(dst, tag, src, seq);
    endfunction

    task automatic see_out(input int o, input logic [12:0] d);
        int idx;
        idx = int'(d[7]) * 2 + o;
        chk(d[12] == 1'(o), "R2", d[12], o);
        if (sbq[idx].size() == 0) chk(1'b0, "R8", d, 0);
        else begin
            logic [12:0] e;
            e = sbq[idx].pop_front();
            chk(d == e, "R8", d, e);
        end
    endtask

    // called just after a negedge with inputs driven; ends at the next negedge
    task automatic step();
        #1;
        if (in0_valid && in0_ready) begin
            sbq[int'(in0_data[12])].push_back(in0_data);
            if (in0_data[11:8] == match_tag) exp_cnt++;
        end
        if (in1_valid && in1_ready) begin
            sbq[2 + int'(in1_data[12])].push_back(in1_data);
            if (in1_data[11:8] == match_tag) exp_cnt++;
        end
        if (out0_valid && out0_ready) see_out(0, out0_data);
        if (out1_valid && out1_ready) see_out(1, out1_data);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain(input int n);
        in0_valid = 0; in1_valid = 0; out0_ready = 1; out1_ready = 1;
        for (int k = 0; k < n; k++) step();
        out0_ready = 0; out1_ready = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        logic [12:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in0_ready && in1_ready, "R1", {in1_ready, in0_ready}, 2'b11);
        chk(!out0_valid && !out1_valid, "R1", {out1_valid, out0_valid}, 0);
        chk(count_value == 0, "R1", count_value, 0);
        // R3 idle inputs forward nothing
        step(); step();
        chk(!out0_valid && !out1_valid, "R3", {out1_valid, out0_valid}, 0);

        // R6/R7: different outputs move together, counter +2 in one cycle
        a = nxt(0, 4'h5, 0); b = nxt(1, 4'h5, 1);
        in0_data = a; in1_data = b; in0_valid = 1; in1_valid = 1;
        step();
        in0_valid = 0; in1_valid = 0;
        chk(count_value == 0 && !out0_valid, "R6", count_value, 0);
        step();
        chk(count_value == 2, "R7", count_value, 2);
        chk(out0_valid && out0_data == a, "R6", out0_data, a);
        chk(out1_valid && out1_data == b, "R2", out1_data, b);
        drain(2);

        // R4/R5: first contest on output 0 goes to input 0
        base = count_value;
        a = nxt(0, 4'h5, 0); b = nxt(0, 4'h5, 1);
        in0_data = a; in1_data = b; in0_valid = 1; in1_valid = 1;
        step();
        in0_valid = 0; in1_valid = 0;
        step();
        chk(count_value == base + 1, "R4", count_value, base + 1);
        chk(out0_data == a, "R5", out0_data, a);
        step();
        chk(count_value == base + 2, "R5", count_value, base + 2);
        out0_ready = 1; step();
        chk(out0_valid && out0_data == b, "R5", out0_data, b);
        drain(2);

        // R5: next contest on output 0 goes to input 1
        base = count_value;
        a = nxt(0, 4'h5, 0); b = nxt(0, 4'h5, 1);
        in0_data = a; in1_data = b; in0_valid = 1; in1_valid = 1;
        step();
        in0_valid = 0; in1_valid = 0;
        step();
        chk(out0_data == b, "R5", out0_data, b);
        chk(count_value == base + 1, "R4", count_value, base + 1);
        drain(4);

        // R3/R8: output 0 blocked, depth 4 on each queue
        base = count_value;
        for (int k = 0; k < 8; k++) begin
            in0_data = nxt(0, 4'h5, 0); in0_valid = 1;
            step();
        end
        in0_valid = 0;
        chk(!in0_ready, "R8", in0_ready, 0);
        step(); step(); step();
        chk(count_value == base + 4, "R3", count_value, base + 4);
        chk(!in0_ready, "R3", in0_ready, 0);
        drain(14);
        chk(count_value == base + 8, "R3", count_value, base + 8);
        chk(sbq[0].size() == 0, "R8", sbq[0].size(), 0);

        // R9: programmable match value
        match_tag = 4'h9;
        base = count_value;
        in0_data = nxt(1, 4'h9, 0); in1_data = nxt(0, 4'h5, 1);
        in0_valid = 1; in1_valid = 1;
        step();
        drain(4);
        chk(count_value == base + 1, "R9", count_value, base + 1);
        match_tag = 4'h5;

        // random traffic
        exp_cnt = count_value;
        for (int k = 0; k < 4000; k++) begin
            in0_valid  = ($urandom % 2) == 0;
            in1_valid  = ($urandom % 2) == 0;
            in0_data   = nxt(1'($urandom), (($urandom % 3) == 0) ? 4'h5 : 4'($urandom), 0);
            in1_data   = nxt(1'($urandom), (($urandom % 3) == 0) ? 4'h5 : 4'($urandom), 1);
            out0_ready = ($urandom % 4) != 0;
            out1_ready = ($urandom % 4) != 0;
            step();
        end
        drain(30);
        chk(count_value == exp_cnt, "R7", count_value, exp_cnt);
        for (int q = 0; q < 4; q++)
            chk(sbq[q].size() == 0, "R8", sbq[q].size(), 0);
        finish_run();
    end
endmodule